// File: doc/BRIEF.md
# Burst Address Sequencer for a Synchronous Memory

This block produces the address sequence for short bursts into a synchronous memory. On a clock edge with the advance/load input low, it takes a full starting address and records the request's kind. A request is active only when both of its enables are in their active state; it is then a read or a write, depending on the write enable. On each later edge with advance/load high, it steps the low address bits, so one supplied address covers up to four accesses.

The ordering input picks one of two step patterns. Interleaved order combines the step count with the starting low bits by exclusive-OR. Linear order adds the step count to them, modulo the burst length. While a burst advances, the block ignores the request controls and the address input. The upper address bits and the recorded kind hold until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the step count clears, `cur_addr` becomes all zeros and `acc_kind` becomes 00 (idle) after that edge.
- R2: When `adv_ld` is 0 at a rising edge, `cur_addr` equals the `addr_in` sampled at that edge, in both orderings, from the next cycle on.
- R3: A load records the kind on `acc_kind`. The request is active when `sel_act` = 1 and `sel_bar` = 0. An active request with `wr_en` = 1 gives 10 (write), an active request with `wr_en` = 0 gives 01 (read), and any other enable combination gives 00 (idle).
- R4: When `adv_ld` is 1 at a rising edge, `acc_kind` keeps its value whatever `sel_act`, `sel_bar`, `wr_en` and `addr_in` carry. A burst loaded as idle therefore stays idle until the next load.
- R5: With `order_sel` = 1 (interleaved), the low two bits of `cur_addr` after k advances equal start XOR (k mod 4). A start of 01 gives 01, 00, 11, 10.
- R6: With `order_sel` = 0 (linear), the low two bits after k advances equal (start + k) mod 4. A start of 10 gives 10, 11, 00, 01.
- R7: Advancing never changes `cur_addr` above bit 1. Those bits stay as loaded.
- R8: After four advances the low bits return to the starting value, and the pattern repeats for as long as `adv_ld` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| adv_ld | input | 1 | 0 = load a new start address and request, 1 = advance the burst |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | ADDR_W | Starting address, sampled on a load |
| sel_act | input | 1 | Request enable, active high |
| sel_bar | input | 1 | Request enable, active low |
| wr_en | input | 1 | 1 = write request, 0 = read request |
| cur_addr | output | ADDR_W | Address of the current access |
| acc_kind | output | 2 | Recorded kind: 00 idle, 01 read, 10 write |

## Verification
The bench builds the block with `ADDR_W` = 6 and the default burst length of four, which leaves only four upper address bits. Every upper value, every start offset, both orderings and all eight enable/write combinations can then be loaded. Each load is followed by six advances, so every burst also wraps. During each advance the bench drives the complemented address and rotating control values, which shows that the inputs it should ignore have no effect. A final reset during a burst confirms the return to the cleared state.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // Kind of access recorded at the start of a burst.
    typedef enum logic [1:0] {
        KIND_IDLE  = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10
    } kind_e;

    // Burst ordering, as selected by the ordering input.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_INTLV  = 1'b1
    } order_e;

    // Per-cycle command decoded from the advance/load input.
    typedef struct packed {
        logic load;
        logic adv;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic adv_ld);
        cmd_t c;
        c.load = ~adv_ld;
        c.adv  = adv_ld;
        return c;
    endfunction

    function automatic kind_e classify(input logic sel_act,
                                       input logic sel_bar,
                                       input logic wr_en);
        if (sel_act && !sel_bar)
            return wr_en ? KIND_WRITE : KIND_READ;
        return KIND_IDLE;
    endfunction

endpackage

// File: rtl/bseq_step_ctr.sv
module bseq_step_ctr #(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bseq_pkg::cmd_t   cmd,
    output logic [LOW_W-1:0] step_q
);
    // Free-running modulo counter: wraps naturally at the burst length.
    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (cmd.load)
            step_q <= '0;
        else if (cmd.adv)
            step_q <= step_q + LOW_W'(1);
    end
endmodule

// File: rtl/bseq_req_capture.sv
module bseq_req_capture #(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  bseq_pkg::cmd_t          cmd,
    input  logic [ADDR_W-1:0]       addr_in,
    input  logic                    sel_act,
    input  logic                    sel_bar,
    input  logic                    wr_en,
    output logic [ADDR_W-LOW_W-1:0] base_q,
    output logic [LOW_W-1:0]        start_q,
    output bseq_pkg::kind_e         kind_q
);
    import bseq_pkg::*;

    // Everything is captured only on a load; advance cycles leave it alone.
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            start_q <= '0;
            kind_q  <= KIND_IDLE;
        end else if (cmd.load) begin
            base_q  <= addr_in[ADDR_W-1:LOW_W];
            start_q <= addr_in[LOW_W-1:0];
            kind_q  <= classify(sel_act, sel_bar, wr_en);
        end
    end
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map #(
    parameter int LOW_W = 2
) (
    input  logic             [LOW_W-1:0] start,
    input  logic             [LOW_W-1:0] step,
    input  bseq_pkg::order_e             order,
    output logic             [LOW_W-1:0] low
);
    import bseq_pkg::*;

    logic [LOW_W-1:0] intlv_low;
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W:0]   carry;

    // Interleaved: bitwise XOR, no carry chain.
    // Linear: explicit ripple adder, wrapping by dropping the top carry.
    assign carry[0] = 1'b0;
    for (genvar b = 0; b < LOW_W; b++) begin : g_bit
        assign intlv_low[b] = start[b] ^ step[b];
        assign lin_low[b]   = start[b] ^ step[b] ^ carry[b];
        assign carry[b+1]   = (start[b] & step[b]) | (carry[b] & (start[b] ^ step[b]));
    end

    always_comb begin
        if (order == ORD_INTLV)
            low = intlv_low;
        else
            low = lin_low;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
    parameter int ADDR_W    = 20,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_ld,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              sel_act,
    input  logic              sel_bar,
    input  logic              wr_en,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        acc_kind
);
    import bseq_pkg::*;

    localparam int LOW_W = $clog2(BURST_LEN);

    cmd_t                    cmd;
    logic [LOW_W-1:0]        step_q;
    logic [LOW_W-1:0]        start_q;
    logic [LOW_W-1:0]        low_addr;
    logic [ADDR_W-LOW_W-1:0] base_q;
    kind_e                   kind_q;
    order_e                  order;

    assign cmd   = decode_cmd(adv_ld);
    assign order = order_e'(order_sel);

    bseq_step_ctr #(.LOW_W(LOW_W)) u_step (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .step_q (step_q)
    );

    bseq_req_capture #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_in (addr_in),
        .sel_act (sel_act),
        .sel_bar (sel_bar),
        .wr_en   (wr_en),
        .base_q  (base_q),
        .start_q (start_q),
        .kind_q  (kind_q)
    );

    bseq_order_map #(.LOW_W(LOW_W)) u_map (
        .start (start_q),
        .step  (step_q),
        .order (order),
        .low   (low_addr)
    );

    assign cur_addr = {base_q, low_addr};
    assign acc_kind = kind_q;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 20,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              adv_ld,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [1:0]        acc_kind,
    input logic [LOW_W-1:0]  step_q
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && acc_kind == 2'b00 && step_q == '0)); // R1

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        !adv_ld |=> cur_addr == $past(addr_in)); // R2

    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
        acc_kind != 2'b11); // R3

    AST_ADV_KIND_HOLD: assert property (@(posedge clk) disable iff (rst)
        adv_ld |=> $stable(acc_kind)); // R4

    AST_INTLV_EVEN_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_ld && order_sel && !step_q[0]) |=>
        (!order_sel || (cur_addr[LOW_W-1:0] ^ $past(cur_addr[LOW_W-1:0])) == LOW_W'(1))); // R5

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_ld && !order_sel) |=>
        (order_sel || cur_addr[LOW_W-1:0] == $past(cur_addr[LOW_W-1:0]) + LOW_W'(1))); // R6

    AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        adv_ld |=> cur_addr[ADDR_W-1:LOW_W] == $past(cur_addr[ADDR_W-1:LOW_W])); // R7

    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv_ld |=> step_q == $past(step_q) + LOW_W'(1)); // R8
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .adv_ld    (adv_ld),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .cur_addr  (cur_addr),
    .acc_kind  (acc_kind),
    .step_q    (step_q)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          adv_ld = 1'b0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          sel_act = 1'b0;
    logic          sel_bar = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [1:0]    acc_kind;

    int n_vec  = 0;
    int n_fail = 0;

    // Bench model state
    logic [AW-1:0] m_start;
    logic [1:0]    m_kind;
    int            m_step;
    logic          m_mode;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) uut (
        .clk       (clk),
        .rst       (rst),
        .adv_ld    (adv_ld),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .sel_act   (sel_act),
        .sel_bar   (sel_bar),
        .wr_en     (wr_en),
        .cur_addr  (cur_addr),
        .acc_kind  (acc_kind)
    );

    function automatic logic [1:0] exp_kind(input logic a, input logic b, input logic w);
        if (a && !b) return w ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input int k, input logic md);
        logic [1:0] lo;
        lo = md ? (s[1:0] ^ 2'(k % 4)) : 2'(s[1:0] + 2'(k % 4));
        return {s[AW-1:2], lo};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] ea, input logic [1:0] ek);
        n_vec++;
        if (cur_addr !== ea || acc_kind !== ek) begin
            n_fail++;
            $display("FAIL %s: cur_addr=%b acc_kind=%b expected cur_addr=%b acc_kind=%b",
                     tag, cur_addr, acc_kind, ea, ek);
        end
    endtask

    // Called just after a falling edge: drive, clock, update model, check.
    task automatic cycle(input logic adv, input logic md, input logic [AW-1:0] a,
                         input logic sa, input logic sb, input logic w);
        string tag;
        adv_ld = adv; order_sel = md; addr_in = a;
        sel_act = sa; sel_bar = sb; wr_en = w;
        @(posedge clk);
        if (!adv) begin
            m_start = a; m_kind = exp_kind(sa, sb, w); m_step = 0; m_mode = md;
            tag = "R2 R3 load";
        end else begin
            m_step++;
            tag = m_mode ? "R4 R5 R7 interleaved" : "R4 R6 R7 linear";
            if (m_step >= 4) tag = {tag, " R8 wrap"};
        end
        @(negedge clk);
        check(tag, exp_addr(m_start, m_step, m_mode), m_kind);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", '0, 2'b00);
        rst = 1'b0;

        for (int md = 0; md < 2; md++) begin
            for (int up = 0; up < 16; up++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    for (int ctl = 0; ctl < 8; ctl++) begin
                        logic [AW-1:0] base;
                        base = AW'((up << 2) | lo);
                        cycle(1'b0, md[0], base, ctl[0], ctl[1], ctl[2]);
                        // Advances: ignored inputs toggle against the loaded ones.
                        for (int k = 0; k < 6; k++) begin
                            cycle(1'b1, md[0], ~base, ~ctl[0] ^ k[0], ~ctl[1], ~ctl[2] ^ k[1]);
                        end
                    end
                end
            end
        end

        // Reset during a burst returns to the cleared state.
        cycle(1'b0, 1'b0, AW'(6'b101110), 1'b1, 1'b0, 1'b1);
        cycle(1'b1, 1'b0, '0, 1'b0, 1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset mid-burst", '0, 2'b00);
        rst = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule